// File: doc/BRIEF.md
# Branch and Call Program-Counter Sequencer

This block owns the program counter of a small 8-bit core whose instructions are 16-bit words in a 21-bit byte-addressed program space. Each cycle in which `fetch_valid` is high, the word on `instr` is the instruction at the address held in `pc`. The block acts on two kinds of instruction and steps past every other word.

The first kind is a branch on the Zero flag with an 8-bit signed word offset. A taken branch inserts one idle bubble cycle, which is flagged on `flush`. The second kind is an absolute subroutine call split over two fetched words. When it completes, it pushes its return address onto an internal return stack. It can also copy the working, status and bank-select registers into single-level shadow copies.

Addresses are always even. The program counter wraps modulo 2^21.

Top module: `brcall_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `pc`=0, `stack_depth`=0, `stack_top`=0, `stack_overflow`=0, `flush`=0 and all three shadow outputs 0.
- R2: `pc` bit 0 is always 0. All address arithmetic wraps modulo 2^21.
- R3: A branch word has bits 15:8 equal to 8'hE0 and bits 7:0 holding a two's-complement offset n. If `zero_flag` is 1, `pc` becomes pc+2+2n. The following cycle is a bubble: `flush`=1, `pc` holds, and the fetched word is ignored.
- R4: A branch word with `zero_flag`=0 advances `pc` by 2, and no bubble follows.
- R5: A call first word has bits 15:9 equal to 7'b1110110. Bit 8 is the save flag s and bits 7:0 are k[7:0]. This word advances `pc` by 2 and pushes nothing.
- R6: A word with bits 15:12 equal to 4'hF, fetched as the next valid word after a call first word, completes the call. Its bits 11:0 are k[19:8]. In that cycle `push_valid`=1 and `push_data` equals the call address plus 4. Afterwards `pc`={k,1'b0}, `stack_depth` rises by 1 and `stack_top` holds the pushed address.
- R7: When s=1, the completing cycle copies `w_in`, `status_in` and `bsr_in` into the shadow outputs. When s=0, the shadow outputs keep their values.
- R8: The return stack holds 31 entries. A push while it is full leaves `stack_depth` and `stack_top` unchanged, and sets `stack_overflow`. The flag stays set until reset.
- R9: A 4'hF word that does not follow a call first word acts as a no-operation and advances `pc` by 2.
- R10: Any other word advances `pc` by 2. A cycle with `fetch_valid`=0 leaves all state unchanged.
- R11: If the word after a call first word is not a 4'hF word, the call is dropped and that word is decoded as a fresh instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | `instr` holds the word at `pc` |
| instr | input | 16 | Fetched instruction word |
| zero_flag | input | 1 | Zero condition from the status logic |
| w_in | input | 8 | Current working register |
| status_in | input | 8 | Current status register |
| bsr_in | input | 8 | Current bank-select register |
| pc | output | 21 | Program counter (byte address) |
| flush | output | 1 | Bubble cycle after a taken branch |
| push_valid | output | 1 | Return address pushed this cycle |
| push_data | output | 21 | Return address being pushed |
| stack_top | output | 21 | Top return-stack entry, 0 when empty |
| stack_depth | output | 5 | Number of stacked entries |
| stack_overflow | output | 1 | Sticky push-when-full flag |
| shadow_w | output | 8 | Shadow working register |
| shadow_status | output | 8 | Shadow status register |
| shadow_bsr | output | 8 | Shadow bank-select register |

## Verification
Most internal errors reach `pc` on the very next edge. A wrong branch offset, a lost call low byte or a missed wrap all show up there, and a stuck bubble shows as `flush` staying high a second cycle. A stale pending-call state shows only when the next 4'hF word arrives: a push occurs where none should, or an expected push is missing. A stack pointer error shows on `stack_depth` and `stack_top` after the push, and at the latest on the 32nd call, when overflow should engage.

// File: rtl/brcall_pkg.sv
package brcall_pkg;

   typedef enum logic [1:0] {
      SEQ_RUN,
      SEQ_CALL2,
      SEQ_BUBBLE
   } seq_state_e;

   typedef enum logic [1:0] {
      IK_OTHER,
      IK_BRANCH,
      IK_CALL_LO,
      IK_CALL_HI
   } instr_kind_e;

   localparam logic [7:0] OPC_BRANCH  = 8'hE0;
   localparam logic [6:0] OPC_CALL_LO = 7'b1110110;
   localparam logic [3:0] OPC_CALL_HI = 4'hF;

endpackage

// File: rtl/brcall_decode.sv
module brcall_decode
   import brcall_pkg::*;
#(
   parameter int PC_W = 21
) (
   input  logic [15:0]     instr,
   input  logic [PC_W-1:0] pc_cur,
   output instr_kind_e     kind,
   output logic [PC_W-1:0] pc_seq,
   output logic [PC_W-1:0] br_target,
   output logic [7:0]      k_lo,
   output logic [11:0]     k_hi,
   output logic            save_bit
);
   localparam int EXT_W = PC_W - 9;

   logic [PC_W-1:0] offset;

   always_comb begin
      if (instr[15:8] == OPC_BRANCH)
         kind = IK_BRANCH;
      else if (instr[15:9] == OPC_CALL_LO)
         kind = IK_CALL_LO;
      else if (instr[15:12] == OPC_CALL_HI)
         kind = IK_CALL_HI;
      else
         kind = IK_OTHER;
   end

   // word offset scaled to bytes, sign-extended to PC width
   assign offset    = {{EXT_W{instr[7]}}, instr[7:0], 1'b0};
   assign pc_seq    = pc_cur + PC_W'(2);
   assign br_target = pc_seq + offset;
   assign k_lo      = instr[7:0];
   assign k_hi      = instr[11:0];
   assign save_bit  = instr[8];

endmodule

// File: rtl/brcall_retstack.sv
module brcall_retstack #(
   parameter int DEPTH = 31,
   parameter int W     = 21
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     top,
   output logic [$clog2(DEPTH+1)-1:0] depth,
   output logic             overflow
);
   localparam int SP_W = $clog2(DEPTH + 1);
   localparam int IX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]    mem [DEPTH];
   logic [SP_W-1:0] sp;
   logic            full;

   assign full = (sp == SP_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (rst) begin
         sp       <= '0;
         overflow <= 1'b0;
      end else if (push) begin
         if (full) begin
            overflow <= 1'b1;
         end else begin
            sp <= sp + SP_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full)
         mem[IX_W'(sp)] <= din;
   end

   always_comb begin
      if (sp == '0)
         top = '0;
      else
         top = mem[IX_W'(sp - SP_W'(1))];
   end

   assign depth = sp;

   // R8
   full_push_chk: assert property (@(posedge clk) disable iff (rst)
      (push && full) |=> (overflow && top == $past(top) && depth == $past(depth)));

   // R8
   sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow);

   // R6
   push_grow_chk: assert property (@(posedge clk) disable iff (rst)
      (push && !full) |=> (depth == $past(depth) + SP_W'(1) && top == $past(din)));

endmodule

// File: rtl/brcall_shadow.sv
module brcall_shadow #(
   parameter int DATA_W    = 8,
   parameter bit SHADOW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              save,
   input  logic [DATA_W-1:0] w_in,
   input  logic [DATA_W-1:0] status_in,
   input  logic [DATA_W-1:0] bsr_in,
   output logic [DATA_W-1:0] w_sh,
   output logic [DATA_W-1:0] status_sh,
   output logic [DATA_W-1:0] bsr_sh
);
   generate
      if (SHADOW_EN) begin : g_shadow
         always_ff @(posedge clk) begin
            if (rst) begin
               w_sh      <= '0;
               status_sh <= '0;
               bsr_sh    <= '0;
            end else if (save) begin
               w_sh      <= w_in;
               status_sh <= status_in;
               bsr_sh    <= bsr_in;
            end
         end

         // R7
         shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !save |=> ($stable(w_sh) && $stable(status_sh) && $stable(bsr_sh)));

         // R7
         shadow_load_chk: assert property (@(posedge clk) disable iff (rst)
            save |=> (w_sh == $past(w_in) && bsr_sh == $past(bsr_in)));
      end else begin : g_no_shadow
         assign w_sh      = '0;
         assign status_sh = '0;
         assign bsr_sh    = '0;
      end
   endgenerate

endmodule

// File: rtl/brcall_seq.sv
module brcall_seq
   import brcall_pkg::*;
#(
   parameter int PC_W        = 21,
   parameter int DATA_W      = 8,
   parameter int STACK_DEPTH = 31,
   parameter bit SHADOW_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fetch_valid,
   input  logic [15:0]       instr,
   input  logic              zero_flag,
   input  logic [DATA_W-1:0] w_in,
   input  logic [DATA_W-1:0] status_in,
   input  logic [DATA_W-1:0] bsr_in,
   output logic [PC_W-1:0]   pc,
   output logic              flush,
   output logic              push_valid,
   output logic [PC_W-1:0]   push_data,
   output logic [PC_W-1:0]   stack_top,
   output logic [$clog2(STACK_DEPTH+1)-1:0] stack_depth,
   output logic              stack_overflow,
   output logic [DATA_W-1:0] shadow_w,
   output logic [DATA_W-1:0] shadow_status,
   output logic [DATA_W-1:0] shadow_bsr
);
   localparam int K_W = 20;

   generate
      if (PC_W < K_W + 1) begin : g_bad_pc
         $error("PC_W must hold a 20-bit word address plus bit 0");
      end
      if (STACK_DEPTH < 1) begin : g_bad_depth
         $error("STACK_DEPTH must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
   endgenerate

   seq_state_e      state_q, state_d;
   logic [PC_W-1:0] pc_q, pc_d;
   logic [7:0]      klo_q;
   logic            save_q;
   logic            latch_call;
   logic            do_push;
   logic            do_save;

   instr_kind_e     kind;
   logic [PC_W-1:0] pc_seq;
   logic [PC_W-1:0] br_target;
   logic [7:0]      k_lo;
   logic [11:0]     k_hi;
   logic            save_bit;

   brcall_decode #(.PC_W(PC_W)) u_decode (
      .instr     (instr),
      .pc_cur    (pc_q),
      .kind      (kind),
      .pc_seq    (pc_seq),
      .br_target (br_target),
      .k_lo      (k_lo),
      .k_hi      (k_hi),
      .save_bit  (save_bit)
   );

   always_comb begin
      state_d    = state_q;
      pc_d       = pc_q;
      latch_call = 1'b0;
      do_push    = 1'b0;
      do_save    = 1'b0;
      if (state_q == SEQ_BUBBLE) begin
         state_d = SEQ_RUN;
      end else if (fetch_valid) begin
         if (state_q == SEQ_CALL2 && kind == IK_CALL_HI) begin
            do_push  = 1'b1;
            do_save  = save_q;
            pc_d     = '0;
            pc_d[K_W:0] = {k_hi, klo_q, 1'b0};
            state_d  = SEQ_RUN;
         end else begin
            pc_d    = pc_seq;
            state_d = SEQ_RUN;
            unique case (kind)
               IK_BRANCH: begin
                  if (zero_flag) begin
                     pc_d    = br_target;
                     state_d = SEQ_BUBBLE;
                  end
               end
               IK_CALL_LO: begin
                  latch_call = 1'b1;
                  state_d    = SEQ_CALL2;
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_RUN;
         pc_q    <= '0;
         klo_q   <= '0;
         save_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pc_q    <= pc_d;
         if (latch_call) begin
            klo_q  <= k_lo;
            save_q <= save_bit;
         end
      end
   end

   // pc already points at the second word, so the return address is pc+2
   assign push_valid = do_push;
   assign push_data  = pc_seq;
   assign pc         = pc_q;
   assign flush      = (state_q == SEQ_BUBBLE);

   brcall_retstack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
      .clk      (clk),
      .rst      (rst),
      .push     (do_push),
      .din      (pc_seq),
      .top      (stack_top),
      .depth    (stack_depth),
      .overflow (stack_overflow)
   );

   brcall_shadow #(.DATA_W(DATA_W), .SHADOW_EN(SHADOW_EN)) u_shadow (
      .clk       (clk),
      .rst       (rst),
      .save      (do_save),
      .w_in      (w_in),
      .status_in (status_in),
      .bsr_in    (bsr_in),
      .w_sh      (shadow_w),
      .status_sh (shadow_status),
      .bsr_sh    (shadow_bsr)
   );

   // R2
   pc_even_chk: assert property (@(posedge clk) disable iff (rst)
      pc[0] == 1'b0);

   // R3
   bubble_once_chk: assert property (@(posedge clk) disable iff (rst)
      flush |=> !flush);

   // R3
   bubble_hold_chk: assert property (@(posedge clk) disable iff (rst)
      flush |=> pc == $past(pc));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!fetch_valid && !flush) |=> $stable(pc));

   // R6
   push_gap_chk: assert property (@(posedge clk) disable iff (rst)
      push_valid |=> !push_valid);

endmodule

// File: tb/brcall_seq_bench.sv
`timescale 1ns/1ps
module brcall_seq_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic        fetch_valid;
   logic [15:0] instr;
   logic        zero_flag;
   logic [7:0]  w_in, status_in, bsr_in;
   logic [20:0] pc, push_data, stack_top;
   logic        flush, push_valid, stack_overflow;
   logic [4:0]  stack_depth;
   logic [7:0]  shadow_w, shadow_status, shadow_bsr;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   brcall_seq u_brcall_seq (
      .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .instr(instr),
      .zero_flag(zero_flag), .w_in(w_in), .status_in(status_in), .bsr_in(bsr_in),
      .pc(pc), .flush(flush), .push_valid(push_valid), .push_data(push_data),
      .stack_top(stack_top), .stack_depth(stack_depth),
      .stack_overflow(stack_overflow), .shadow_w(shadow_w),
      .shadow_status(shadow_status), .shadow_bsr(shadow_bsr)
   );

   // reference model state: 0 run, 1 waiting for call word 2, 2 bubble
   logic [20:0] m_pc;
   int          m_st;
   logic [7:0]  m_klo;
   logic        m_s;
   logic [20:0] m_stk [31];
   int          m_dep;
   logic        m_ovf;
   logic [7:0]  m_w, m_sr, m_b;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [20:0] f_branch(input logic [20:0] p, input logic [7:0] n);
      logic [20:0] off;
      off = {{12{n[7]}}, n, 1'b0};
      return p + 21'd2 + off;
   endfunction

   function automatic logic [20:0] m_top();
      return (m_dep == 0) ? 21'd0 : m_stk[m_dep-1];
   endfunction

   task automatic check_state(input string req);
      chk(pc === m_pc, req, 32'(pc), 32'(m_pc));
      chk(flush === (m_st == 2), req, 32'(flush), 32'(m_st == 2));
      chk(stack_depth === 5'(m_dep), req, 32'(stack_depth), 32'(m_dep));
      chk(stack_top === m_top(), req, 32'(stack_top), 32'(m_top()));
      chk(stack_overflow === m_ovf, req, 32'(stack_overflow), 32'(m_ovf));
      chk({shadow_w, shadow_status, shadow_bsr} === {m_w, m_sr, m_b}, req,
          32'({shadow_w, shadow_status, shadow_bsr}), 32'({m_w, m_sr, m_b}));
   endtask

   task automatic do_reset();
      rst = 1'b1; fetch_valid = 1'b0; instr = '0; zero_flag = 1'b0;
      w_in = '0; status_in = '0; bsr_in = '0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      m_pc = '0; m_st = 0; m_klo = '0; m_s = 1'b0; m_dep = 0; m_ovf = 1'b0;
      m_w = '0; m_sr = '0; m_b = '0;
      check_state("R1");
      rst = 1'b0;
   endtask

   // called at a negedge; applies one cycle of stimulus and checks the result
   task automatic step(input logic v, input logic [15:0] wd, input logic z,
                       input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                       input string req);
      bit exp_push;
      fetch_valid = v; instr = wd; zero_flag = z; w_in = a; status_in = b; bsr_in = c;
      #1;
      exp_push = (m_st == 1) && v && (wd[15:12] == 4'hF);
      chk(push_valid === exp_push, "R6", 32'(push_valid), 32'(exp_push));
      if (exp_push)
         chk(push_data === m_pc + 21'd2, "R6", 32'(push_data), 32'(m_pc + 21'd2));
      if (m_st == 2) begin
         m_st = 0;
      end else if (v) begin
         if (exp_push) begin
            if (m_dep == 31) m_ovf = 1'b1;
            else begin m_stk[m_dep] = m_pc + 21'd2; m_dep++; end
            if (m_s) begin m_w = a; m_sr = b; m_b = c; end
            m_pc = {wd[11:0], m_klo, 1'b0};
            m_st = 0;
         end else if (wd[15:8] == 8'hE0) begin
            m_pc = z ? f_branch(m_pc, wd[7:0]) : m_pc + 21'd2;
            m_st = z ? 2 : 0;
         end else if (wd[15:9] == 7'b1110110) begin
            m_klo = wd[7:0]; m_s = wd[8]; m_pc = m_pc + 21'd2; m_st = 1;
         end else begin
            m_pc = m_pc + 21'd2; m_st = 0;
         end
      end
      @(posedge clk); @(negedge clk);
      check_state(req);
   endtask

   function automatic logic [15:0] rand_word();
      logic [15:0] r;
      r = 16'($urandom);
      case ($urandom % 6)
         0, 5:    return {8'hE0, r[7:0]};
         1:       return {7'b1110110, r[8:0]};
         2:       return {4'hF, r[11:0]};
         default: return r;
      endcase
   endfunction

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'd4242);
      do_reset();

      // R10: idle cycle holds, plain word advances
      step(1'b0, 16'h1234, 1'b1, 8'h0, 8'h0, 8'h0, "R10");
      step(1'b1, 16'h1234, 1'b0, 8'h0, 8'h0, 8'h0, "R10");
      // R4: not taken
      step(1'b1, 16'hE07F, 1'b0, 8'h0, 8'h0, 8'h0, "R4");
      // R3: taken forward n=127, then bubble ignores a call word
      step(1'b1, 16'hE07F, 1'b1, 8'h0, 8'h0, 8'h0, "R3");
      step(1'b1, 16'hED00, 1'b1, 8'h0, 8'h0, 8'h0, "R3");
      // R9: orphan high word
      step(1'b1, 16'hF123, 1'b0, 8'h0, 8'h0, 8'h0, "R9");
      // R5/R6/R7: call with save
      step(1'b1, 16'hED5A, 1'b0, 8'h0, 8'h0, 8'h0, "R5");
      step(1'b1, 16'hF00C, 1'b0, 8'hA1, 8'hB2, 8'hC3, "R7");
      // call without save keeps shadows
      step(1'b1, 16'hEC10, 1'b0, 8'h0, 8'h0, 8'h0, "R5");
      step(1'b1, 16'hF001, 1'b0, 8'h11, 8'h22, 8'h33, "R7");
      // R11: dropped call, the branch after it is decoded
      step(1'b1, 16'hED77, 1'b0, 8'h0, 8'h0, 8'h0, "R11");
      step(1'b1, 16'hE0FE, 1'b1, 8'h5, 8'h5, 8'h5, "R11");
      step(1'b1, 16'hF0FF, 1'b0, 8'h5, 8'h5, 8'h5, "R11");
      // R2: wrap below zero with n=-128 from pc 0
      do_reset();
      step(1'b1, 16'hE080, 1'b1, 8'h0, 8'h0, 8'h0, "R2");
      step(1'b0, 16'h0000, 1'b0, 8'h0, 8'h0, 8'h0, "R2");
      // R2: wrap above top via call to last word
      step(1'b1, 16'hECFF, 1'b0, 8'h0, 8'h0, 8'h0, "R2");
      step(1'b1, 16'hFFFF, 1'b0, 8'h0, 8'h0, 8'h0, "R2");
      step(1'b1, 16'h0000, 1'b0, 8'h0, 8'h0, 8'h0, "R2");

      // random mix
      do_reset();
      for (int i = 0; i < 1500; i++) begin
         step(($urandom % 5) != 0, rand_word(), 1'($urandom),
              8'($urandom), 8'($urandom), 8'($urandom), "R3 R6 random");
      end

      // R8: fill the stack then overflow
      do_reset();
      for (int i = 0; i < 33; i++) begin
         step(1'b1, {7'b1110110, 1'b1, 8'(i)}, 1'b0, 8'(i), 8'(i), 8'(i), "R8");
         step(1'b1, {4'hF, 12'(i)}, 1'b0, 8'(i + 1), 8'(i + 2), 8'(i + 3), "R8");
      end
      step(1'b1, 16'h0000, 1'b0, 8'h0, 8'h0, 8'h0, "R8");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule